// File: doc/BRIEF.md
# Frame Update Sequencing Controller

This block sequences every change to the contents of an LED panel frame store. After reset it writes zero to every frame-store word. It then runs a solid-colour self test: red, then green, then blue, each held for a programmable number of scan frames. After the self test it tells the host that it will accept a frame. When the host reports that a frame is staged in the dual-port staging buffer, the controller waits for the scan driver's end-of-frame pulse. At that pause point it stops the refresh and copies the staging buffer into the frame store, one word per clock. It then flips the buffer-area flag, signals the host again and lets the refresh resume.

The refresh is never stopped in the middle of a scan, because a copy can begin only on the cycle that the scan driver reports a frame end. While the panel is refreshing, the host must first raise data-available to put the controller back into its waiting state. Only then does a data-ready request start another load.

Top module: `frame_seq_ctrl`

## Requirements
- R1: After reset, and before any other activity, the block writes zero to every frame-store address from 0 up to DEPTH-1, one per clock, in ascending order. During this clear, `scan_run` and `host_ready` are low and `test_color` is 0.
- R2: After the clear, `scan_run` is high and `test_color` shows red (1), then green (2), then blue (3). Each colour stays for `hold_frames` pulses of `scan_frame_end`. After that, `test_color` returns to 0 (off).
- R3: When the self test ends, the block enters the wait state and raises `host_ready`.
- R4: In the wait state, `host_drdy` sampled high records a pending load, and `host_ready` is low from the next cycle.
- R5: A copy begins only on a cycle where `scan_frame_end` is high and a load is pending or `host_drdy` is high. Before that cycle the frame store is not written and `scan_run` stays high. `scan_run` falls on the next cycle.
- R6: The copy writes frame-store addresses 0 up to DEPTH-1 in ascending order, one per clock. The data written to each address is the staging word at that address, and the staging buffer has a read latency of one clock. `fs_wr_en` is never high while `scan_run` is high.
- R7: When the copy ends, `area_sel` toggles, `host_ready` rises and `scan_run` returns high. Nothing else changes `area_sel`.
- R8: While the panel is refreshing after a copy, `host_drdy` and `scan_frame_end` have no effect: there are no writes, and both `host_ready` and `area_sel` are unchanged.
- R9: `host_davail` high during the refresh returns the block to the wait state, where a following `host_drdy` is handled as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_frames | input | HOLD_W | Number of frames each self-test colour is held (0 behaves as 1) |
| scan_frame_end | input | 1 | One-cycle pulse from the scan driver at its pause point |
| scan_run | output | 1 | High while the scan driver may refresh |
| test_color | output | 2 | Self-test colour: 0 off, 1 red, 2 green, 3 blue |
| host_drdy | input | 1 | Host reports that a frame is staged |
| host_davail | input | 1 | Host announces new data while refreshing |
| host_ready | output | 1 | Level: block can accept another frame |
| area_sel | output | 1 | Buffer-area flag, toggled by each completed copy |
| stg_rd_addr | output | ADDR_W | Staging-buffer read address |
| stg_rd_data | input | DATA_W | Staging-buffer read data, one clock after the address |
| fs_wr_en | output | 1 | Frame-store write enable |
| fs_wr_addr | output | ADDR_W | Frame-store write address |
| fs_wr_data | output | DATA_W | Frame-store write data |

## Verification
The bench raises a data-ready request while the panel is mid-scan and holds it off for several cycles. A design that began the copy at once would produce writes before any frame end, and the scoreboard would flag them. It also checks that the first copied word is the staging word for address 0. A design that misaligned the one-clock staging latency would write every word to the wrong address. The bench pulses data-ready and frame ends during the refresh to catch a design that reloads without a data-available request, or that toggles the area flag spuriously. Finally, it drives data-ready in the same cycle as a frame end, to catch a design that only honours a request registered on an earlier cycle.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [2:0] {
        S_CLEAR = 3'd0,
        S_TEST  = 3'd1,
        S_WAIT  = 3'd2,
        S_COPY  = 3'd3,
        S_SHOW  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        TONE_OFF   = 2'd0,
        TONE_RED   = 2'd1,
        TONE_GREEN = 2'd2,
        TONE_BLUE  = 2'd3
    } tone_t;

endpackage

// File: rtl/addr_sweep.sv
module addr_sweep #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run) cnt_d = (cnt_q == LAST_ADDR) ? '0 : cnt_q + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign addr = cnt_q;
    assign last = (cnt_q == LAST_ADDR);

    // R6: consecutive addresses while sweeping, wrap to zero after the end
    a_r6_sweep_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> (addr == $past(addr) + ADDR_W'(1)));
    a_r6_sweep_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last) |=> (addr == '0));

endmodule

// File: rtl/tone_timer.sv
module tone_timer
    import frame_seq_pkg::*;
#(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [HOLD_W-1:0] hold,
    output tone_t             colour,
    output logic              finished
);
    typedef struct packed {
        tone_t             tone;
        logic [HOLD_W-1:0] frm;
    } tone_reg_t;

    tone_reg_t r_q, r_d;
    logic [HOLD_W-1:0] hold_eff;

    assign hold_eff = (hold == '0) ? HOLD_W'(1) : hold;

    always_comb begin
        r_d      = r_q;
        finished = 1'b0;
        if (!run) begin
            r_d.tone = TONE_RED;
            r_d.frm  = '0;
        end else if (tick) begin
            if (r_q.frm == hold_eff - HOLD_W'(1)) begin
                r_d.frm = '0;
                if (r_q.tone == TONE_BLUE) begin
                    finished = 1'b1;
                    r_d.tone = TONE_RED;
                end else begin
                    r_d.tone = tone_t'(r_q.tone + 2'd1);
                end
            end else begin
                r_d.frm = r_q.frm + HOLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{tone: TONE_RED, frm: '0};
        else        r_q <= r_d;
    end

    assign colour = run ? r_q.tone : TONE_OFF;

    // R2: after blue completes, the display leaves the test colours
    a_r2_off_after_blue: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> (colour == TONE_OFF));

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
    import frame_seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 24,
    parameter int HOLD_W = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] hold_frames,
    input  logic              scan_frame_end,
    output logic              scan_run,
    output logic [1:0]        test_color,
    input  logic              host_drdy,
    input  logic              host_davail,
    output logic              host_ready,
    output logic              area_sel,
    output logic [ADDR_W-1:0] stg_rd_addr,
    input  logic [DATA_W-1:0] stg_rd_data,
    output logic              fs_wr_en,
    output logic [ADDR_W-1:0] fs_wr_addr,
    output logic [DATA_W-1:0] fs_wr_data
);
    typedef struct packed {
        seq_state_t        st;
        logic              pend;
        logic              rdy;
        logic              area;
        logic              wen;
        logic [ADDR_W-1:0] wadr;
        logic              wsrc;
        logic              done;
    } ctl_t;

    ctl_t r_q, r_d;

    logic              sweep_run, sweep_last, tone_done;
    logic [ADDR_W-1:0] sweep_addr;
    tone_t             tone;

    assign sweep_run = ((r_q.st == S_CLEAR) || (r_q.st == S_COPY)) && !r_q.done;

    addr_sweep #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_sweep (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sweep_run),
        .addr (sweep_addr),
        .last (sweep_last)
    );

    tone_timer #(.HOLD_W(HOLD_W)) u_tone (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == S_TEST),
        .tick    (scan_frame_end),
        .hold    (hold_frames),
        .colour  (tone),
        .finished(tone_done)
    );

    always_comb begin
        r_d      = r_q;
        r_d.wen  = sweep_run;
        r_d.wadr = sweep_addr;
        r_d.wsrc = (r_q.st == S_COPY);
        r_d.done = sweep_run && sweep_last;
        case (r_q.st)
            S_CLEAR: if (r_q.done) r_d.st = S_TEST;
            S_TEST: begin
                if (tone_done) begin
                    r_d.st  = S_WAIT;
                    r_d.rdy = 1'b1;
                end
            end
            S_WAIT: begin
                if (host_drdy) begin
                    r_d.pend = 1'b1;
                    r_d.rdy  = 1'b0;
                end
                if ((r_q.pend || host_drdy) && scan_frame_end) begin
                    r_d.st   = S_COPY;
                    r_d.pend = 1'b0;
                end
            end
            S_COPY: begin
                if (r_q.done) begin
                    r_d.st   = S_SHOW;
                    r_d.rdy  = 1'b1;
                    r_d.area = ~r_q.area;
                end
            end
            S_SHOW: if (host_davail) r_d.st = S_WAIT;
            default: r_d.st = S_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: S_CLEAR, wadr: '0, default: 1'b0};
        else        r_q <= r_d;
    end

    assign scan_run    = (r_q.st == S_TEST) || (r_q.st == S_WAIT) || (r_q.st == S_SHOW);
    assign test_color  = tone;
    assign host_ready  = r_q.rdy;
    assign area_sel    = r_q.area;
    assign stg_rd_addr = sweep_addr;
    assign fs_wr_en    = r_q.wen;
    assign fs_wr_addr  = r_q.wadr;
    assign fs_wr_data  = r_q.wsrc ? stg_rd_data : '0;

    // R1: clear writes carry zero data
    a_r1_clear_writes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CLEAR && fs_wr_en) |-> (fs_wr_data == '0));
    // R6: the frame store is never written while the panel refreshes
    a_r6_no_write_while_scanning: assert property (@(posedge clk) disable iff (!rst_n)
        fs_wr_en |-> !scan_run);
    // R4: a request in the wait state drops ready on the next cycle
    a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT && host_drdy) |=> !host_ready);
    // R5: a copy is entered only from a frame-end pause point
    a_r5_copy_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_COPY && $past(r_q.st) == S_WAIT) |-> $past(scan_frame_end));
    // R7: the area flag moves only as a copy completes
    a_r7_area_flips_on_copy_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(area_sel) |-> ($past(r_q.st) == S_COPY && host_ready));

endmodule

// File: tb/frame_seq_ctrl_bench.sv
module frame_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 12;
    localparam int HOLD_W = 4;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [HOLD_W-1:0] hold_frames = HOLD_W'(2);
    logic              scan_frame_end = 1'b0;
    logic              scan_run;
    logic [1:0]        test_color;
    logic              host_drdy = 1'b0;
    logic              host_davail = 1'b0;
    logic              host_ready;
    logic              area_sel;
    logic [ADDR_W-1:0] stg_rd_addr;
    logic [DATA_W-1:0] stg_rd_data = '0;
    logic              fs_wr_en;
    logic [ADDR_W-1:0] fs_wr_addr;
    logic [DATA_W-1:0] fs_wr_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DATA_W-1:0] stg_mem [DEPTH];
    int                exp_addr[$];
    logic [DATA_W-1:0] exp_data[$];
    string             exp_req[$];
    int                tone_log[$];
    logic              log_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_seq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_frame_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_frames(hold_frames),
        .scan_frame_end(scan_frame_end), .scan_run(scan_run), .test_color(test_color),
        .host_drdy(host_drdy), .host_davail(host_davail), .host_ready(host_ready),
        .area_sel(area_sel), .stg_rd_addr(stg_rd_addr), .stg_rd_data(stg_rd_data),
        .fs_wr_en(fs_wr_en), .fs_wr_addr(fs_wr_addr), .fs_wr_data(fs_wr_data)
    );

    // staging buffer model: one clock read latency
    always @(posedge clk) stg_rd_data <= stg_mem[stg_rd_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pattern(input int a, input int seed);
        return DATA_W'(((a * 37) + (seed * 101) + 5) ^ (a << 3));
    endfunction

    // driver side of the scoreboard
    task automatic push_frame(input int seed, input string req);
        for (int a = 0; a < DEPTH; a++) begin
            exp_addr.push_back(a);
            exp_data.push_back((seed < 0) ? '0 : pattern(a, seed));
            exp_req.push_back(req);
        end
    endtask

    task automatic load_stage(input int seed);
        for (int a = 0; a < DEPTH; a++) stg_mem[a] = pattern(a, seed);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && fs_wr_en) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R5/R8 write with nothing expected", int'(fs_wr_addr), -1);
            end else begin
                int    ea;
                int    ed;
                string rq;
                ea = exp_addr.pop_front();
                ed = int'(exp_data.pop_front());
                rq = exp_req.pop_front();
                check(int'(fs_wr_addr) == ea, {rq, " address"}, int'(fs_wr_addr), ea);
                check(int'(fs_wr_data) == ed, {rq, " data"}, int'(fs_wr_data), ed);
            end
        end
        if (log_on && scan_frame_end) tone_log.push_back(int'(test_color));
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic tick_frame();
        @(posedge clk); #1 scan_frame_end = 1'b1;
        @(posedge clk); #1 scan_frame_end = 1'b0;
    endtask

    task automatic pulse_drdy();
        @(posedge clk); #1 host_drdy = 1'b1;
        @(posedge clk); #1 host_drdy = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        load_stage(1);
        idle(3);
        @(negedge clk);
        check(fs_wr_en == 1'b0,   "R1 reset write enable", int'(fs_wr_en), 0);
        check(host_ready == 1'b0, "R1 reset ready", int'(host_ready), 0);
        check(scan_run == 1'b0,   "R1 reset scan_run", int'(scan_run), 0);
        check(test_color == 2'd0, "R1 reset colour", int'(test_color), 0);
        check(area_sel == 1'b0,   "R1 reset area", int'(area_sel), 0);
        push_frame(-1, "R1 clear");
        @(posedge clk); #1 rst_n = 1'b1;

        // clear takes DEPTH+1 cycles after release
        idle(DEPTH + 3);
        @(negedge clk);
        check(exp_addr.size() == 0, "R1 all clears seen", exp_addr.size(), 0);
        check(scan_run == 1'b1,     "R2 scan during test", int'(scan_run), 1);
        check(test_color == 2'd1,   "R2 first colour red", int'(test_color), 1);
        check(host_ready == 1'b0,   "R3 not ready during test", int'(host_ready), 0);

        log_on = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick_frame();
            idle(2);
        end
        log_on = 1'b0;
        check(tone_log.size() == 6, "R2 frames logged", tone_log.size(), 6);
        for (int i = 0; i < 6 && i < tone_log.size(); i++)
            check(tone_log[i] == (i / 2) + 1, "R2 colour order", tone_log[i], (i / 2) + 1);
        @(negedge clk);
        check(test_color == 2'd0, "R2 colour off after blue", int'(test_color), 0);
        check(host_ready == 1'b1, "R3 ready after test", int'(host_ready), 1);

        // load A: request mid-scan, copy waits for the frame end
        pulse_drdy();
        @(negedge clk);
        check(host_ready == 1'b0, "R4 ready drops on request", int'(host_ready), 0);
        idle(5);
        @(negedge clk);
        check(scan_run == 1'b1, "R5 scan held until frame end", int'(scan_run), 1);
        push_frame(1, "R6 copy A");
        tick_frame();
        @(negedge clk);
        check(scan_run == 1'b0, "R5 scan paused after frame end", int'(scan_run), 0);
        idle(DEPTH + 3);
        @(negedge clk);
        check(exp_addr.size() == 0, "R6 all words of A copied", exp_addr.size(), 0);
        check(host_ready == 1'b1,   "R7 ready after copy", int'(host_ready), 1);
        check(area_sel == 1'b1,     "R7 area toggled", int'(area_sel), 1);
        check(scan_run == 1'b1,     "R7 scan resumed", int'(scan_run), 1);

        // refresh: requests ignored without data-available
        load_stage(2);
        pulse_drdy();
        tick_frame();
        idle(2);
        tick_frame();
        idle(3);
        @(negedge clk);
        check(host_ready == 1'b1, "R8 ready unchanged", int'(host_ready), 1);
        check(area_sel == 1'b1,   "R8 area unchanged", int'(area_sel), 1);

        // data-available, then request coinciding with a frame end
        @(posedge clk); #1 host_davail = 1'b1;
        @(posedge clk); #1 host_davail = 1'b0;
        idle(2);
        push_frame(2, "R9 copy B");
        @(posedge clk); #1 begin host_drdy = 1'b1; scan_frame_end = 1'b1; end
        @(posedge clk); #1 begin host_drdy = 1'b0; scan_frame_end = 1'b0; end
        @(negedge clk);
        check(scan_run == 1'b0, "R9 copy started from wait", int'(scan_run), 0);
        idle(DEPTH + 3);
        @(negedge clk);
        check(exp_addr.size() == 0, "R9 all words of B copied", exp_addr.size(), 0);
        check(area_sel == 1'b0,     "R7 area toggled back", int'(area_sel), 0);
        check(host_ready == 1'b1,   "R7 ready after second copy", int'(host_ready), 1);

        summary();
        $finish;
    end

endmodule